// File: doc/BRIEF.md
# Frame Header Slot-Map Filter

This block sits on the receive byte stream of a terminal's radio link. Each frame opens with a frame header packet whose body carries a slot map: a list of 4-byte entries, each assigning one slot of the frame to an uplink, downlink or silent use. The sequencer tells the filter which packets are frame headers. For those packets the filter skips the fixed 27-byte MAC header, then assembles the slot-map entries that follow. It keeps only the entries meant for this terminal, or for all terminals, and writes them into a small FIFO that the host drains.

Every other packet passes by with no effect. The terminal's own address comes from a configuration input that is set at initialisation. Two counters describe the most recent frame header: how many entries were written to the FIFO, and how many matching entries were lost because the FIFO was full.

Top module: `slot_map_filter`

## Requirements
- R1: A packet is parsed only if `rx_is_fh` is high on its first byte (the byte with `rx_sop` and `rx_valid`). Any other packet writes no entry and leaves both counters unchanged.
- R2: The first 27 bytes of a parsed packet are skipped. Entries begin at byte index 27 and are packed 4 bytes each, most significant byte first. In an entry, bits [31:29] hold the kind, [28:21] the terminal address, [20:9] the virtual-channel field and [8:0] the slot number. The kind codes are: 0 void, 1 uplink reserved, 2 uplink contention, 3 downlink unicast, 4 downlink group, 5 and 6 spare.
- R3: An entry whose address field equals `my_mt_addr` is forwarded unchanged.
- R4: An entry whose address field is 8'hFF is forwarded whatever `my_mt_addr` holds. Entries with any other address are discarded.
- R5: An entry of kind 3'b111 ends the slot map. It is not forwarded, and every later byte of that packet is ignored.
- R6: The byte with `rx_eop` ends parsing. An entry completed on that byte is still processed. A trailing entry with fewer than 4 bytes is discarded.
- R7: Forwarded entries leave the FIFO in arrival order. The oldest entry is shown on `ent_data` while `ent_valid` is high, and `ent_ready` removes it. The FIFO holds DEPTH entries (default 4). An entry becomes visible one cycle after its last byte is accepted.
- R8: A matching entry that arrives while the FIFO is full is dropped and adds one to `drop_count`.
- R9: The first byte of a frame header clears `accept_count` and `drop_count`. From then on, `accept_count` adds one for each entry written into the FIFO.
- R10: After reset, `ent_valid` is low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_mt_addr | input | 8 | This terminal's address |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| rx_is_fh | input | 1 | Sequencer marks the packet as a frame header (sampled with the first byte) |
| ent_ready | input | 1 | Host removes the shown entry |
| ent_valid | output | 1 | FIFO holds at least one entry |
| ent_data | output | 32 | Oldest forwarded entry |
| accept_count | output | CNT_W | Entries written during the latest frame header |
| drop_count | output | CNT_W | Matching entries lost to a full FIFO during the latest frame header |

## Verification
The bench targets the points where a faulty design goes wrong:
- Off-by-one header skipping would misalign every entry, so all forwarded fields would come out shifted.
- A non-frame-header packet full of matching entries would fill the FIFO if the frame-header flag were ignored.
- Filling the FIFO past its depth would show whether a design overwrites stored entries or fails to count the drops.

It also drives an end-of-map entry followed by more matching entries, a packet cut off partway through an entry, a packet that ends exactly on an entry boundary, broadcast entries while the configured address differs, and back-to-back frame headers without draining. Random packets with idle gaps and changing addresses then check the counters and the FIFO contents against a bench model.

// File: rtl/fhf_pkg.sv
package fhf_pkg;

    localparam int HDR_BYTES = 27;
    localparam int ENT_W     = 32;

    typedef logic [2:0] kind_t;
    localparam kind_t K_VOID    = 3'd0;
    localparam kind_t K_UL_RES  = 3'd1;
    localparam kind_t K_UL_CONT = 3'd2;
    localparam kind_t K_DL_UNI  = 3'd3;
    localparam kind_t K_DL_GRP  = 3'd4;
    localparam kind_t K_END     = 3'd7;

    localparam logic [7:0] ADDR_ALL = 8'hFF;

    typedef struct packed {
        kind_t       kind;
        logic [7:0]  mt;
        logic [11:0] mvc;
        logic [8:0]  slot;
    } slot_ent_t;

    function automatic logic ent_is_mine(slot_ent_t e, logic [7:0] addr);
        return (e.mt == addr) || (e.mt == ADDR_ALL);
    endfunction

endpackage

// File: rtl/fhf_fifo.sv
module fhf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      count;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign rd_data = mem[rptr];

    logic do_wr, do_rd;
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) begin
                mem[wptr] <= wr_data;
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_rd)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));
    // R7: an empty FIFO with no write stays empty
    a_r7_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (empty && !wr_en) |=> empty);

endmodule

// File: rtl/fhf_assembler.sv
module fhf_assembler
    import fhf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic [7:0] in_byte,
    input  logic      in_sop,
    input  logic      in_eop,
    input  logic      in_fh,
    output logic      fh_start,
    output logic      ent_strobe,
    output slot_ent_t ent
);
    localparam int HW = $clog2(HDR_BYTES + 1);
    localparam logic [HW-1:0] HDR_LAST = HW'(HDR_BYTES - 1);

    typedef enum logic [1:0] {P_IDLE, P_HDR, P_MAP} pstate_t;

    pstate_t       state;
    logic [HW-1:0] hdr_cnt;
    logic [1:0]    idx;
    logic [23:0]   shreg;

    assign fh_start   = in_valid && in_sop && in_fh;
    assign ent        = slot_ent_t'({shreg, in_byte});
    assign ent_strobe = (state == P_MAP) && in_valid && !in_sop &&
                        (idx == 2'd3) && (ent.kind != K_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= P_IDLE;
            hdr_cnt <= '0;
            idx     <= '0;
            shreg   <= '0;
        end else if (in_valid) begin
            if (in_sop) begin
                hdr_cnt <= HW'(1);
                idx     <= '0;
                state   <= (in_fh && !in_eop) ? P_HDR : P_IDLE;
            end else begin
                case (state)
                    P_HDR: begin
                        hdr_cnt <= hdr_cnt + 1'b1;
                        if (in_eop)
                            state <= P_IDLE;
                        else if (hdr_cnt == HDR_LAST) begin
                            state <= P_MAP;
                            idx   <= '0;
                        end
                    end
                    P_MAP: begin
                        shreg <= {shreg[15:0], in_byte};
                        idx   <= idx + 1'b1;
                        if (in_eop || (idx == 2'd3 && ent.kind == K_END))
                            state <= P_IDLE;
                    end
                    default: state <= P_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/fhf_select.sv
module fhf_select
    import fhf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       my_addr,
    input  logic             fh_start,
    input  logic             ent_strobe,
    input  slot_ent_t        ent,
    input  logic             fifo_full,
    output logic             push,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] drop_cnt
);
    logic mine, drop;
    assign mine = ent_strobe && ent_is_mine(ent, my_addr);
    assign push = mine && !fifo_full;
    assign drop = mine && fifo_full;

    always_ff @(posedge clk) begin
        if (rst || fh_start) begin
            acc_cnt  <= '0;
            drop_cnt <= '0;
        end else begin
            if (push) acc_cnt  <= acc_cnt + 1'b1;
            if (drop) drop_cnt <= drop_cnt + 1'b1;
        end
    end

    // R9: a frame header start leaves both counters at zero
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        fh_start |=> (acc_cnt == '0 && drop_cnt == '0));
    // R8: the drop counter grows only while the FIFO reports full
    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt != $past(drop_cnt) && drop_cnt != '0) |-> $past(fifo_full));

endmodule

// File: rtl/slot_map_filter.sv
module slot_map_filter
    import fhf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       my_mt_addr,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_sop,
    input  logic             rx_eop,
    input  logic             rx_is_fh,
    input  logic             ent_ready,
    output logic             ent_valid,
    output logic [31:0]      ent_data,
    output logic [CNT_W-1:0] accept_count,
    output logic [CNT_W-1:0] drop_count
);
    logic      fh_start, ent_strobe, push, fifo_empty, fifo_full;
    slot_ent_t ent;

    fhf_assembler u_asm (
        .clk(clk), .rst(rst),
        .in_valid(rx_valid), .in_byte(rx_byte), .in_sop(rx_sop),
        .in_eop(rx_eop), .in_fh(rx_is_fh),
        .fh_start(fh_start), .ent_strobe(ent_strobe), .ent(ent)
    );

    fhf_select #(.CNT_W(CNT_W)) u_sel (
        .clk(clk), .rst(rst), .my_addr(my_mt_addr),
        .fh_start(fh_start), .ent_strobe(ent_strobe), .ent(ent),
        .fifo_full(fifo_full), .push(push),
        .acc_cnt(accept_count), .drop_cnt(drop_count)
    );

    fhf_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(push), .wr_data(ent),
        .rd_en(ent_ready), .rd_data(ent_data),
        .empty(fifo_empty), .full(fifo_full)
    );

    assign ent_valid = !fifo_empty;

    // R5: the end-of-map kind is never written
    a_r5_no_end_written: assert property (@(posedge clk) disable iff (rst)
        push |-> (ent.kind != K_END));
    // R3 / R4: writes carry this terminal's address or the all-terminals address
    a_r3_r4_match: assert property (@(posedge clk) disable iff (rst)
        push |-> (ent.mt == my_mt_addr || ent.mt == ADDR_ALL));
    // R1: nothing is written on the first byte of any packet
    a_r1_no_write_on_sop: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sop) |-> !push);

endmodule

// File: tb/slot_map_filter_test.sv
module slot_map_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int CNT_W = 8;

    logic clk = 0, rst = 1;
    logic [7:0] my_mt_addr = 8'h21;
    logic rx_valid = 0, rx_sop = 0, rx_eop = 0, rx_is_fh = 0, ent_ready = 0;
    logic [7:0] rx_byte = 0;
    logic ent_valid;
    logic [31:0] ent_data;
    logic [CNT_W-1:0] accept_count, drop_count;

    slot_map_filter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .my_mt_addr(my_mt_addr),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_is_fh(rx_is_fh), .ent_ready(ent_ready),
        .ent_valid(ent_valid), .ent_data(ent_data),
        .accept_count(accept_count), .drop_count(drop_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] pkt_ents[$];
    int exp_acc = 0, exp_drop = 0;
    logic gaps = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] k, input logic [7:0] mt,
                                       input logic [11:0] mvc, input logic [8:0] sl);
        return {k, mt, mvc, sl};
    endfunction

    // bench model of R1..R9 with no reads during a packet
    task automatic model_pkt(input logic fh);
        if (!fh) return;
        exp_acc = 0; exp_drop = 0;
        foreach (pkt_ents[i]) begin
            logic [31:0] e = pkt_ents[i];
            if (e[31:29] == 3'b111) break;
            if (e[28:21] == my_mt_addr || e[28:21] == 8'hFF) begin
                if (exp_q.size() < DEPTH) begin exp_q.push_back(e); exp_acc++; end
                else exp_drop++;
            end
        end
    endtask

    task automatic send_pkt(input logic fh, input int partial);
        logic [7:0] b[$];
        for (int i = 0; i < 27; i++) b.push_back(8'($urandom));
        foreach (pkt_ents[i])
            for (int j = 3; j >= 0; j--) b.push_back(pkt_ents[i][j*8 +: 8]);
        for (int i = 0; i < partial; i++) b.push_back(8'($urandom));
        model_pkt(fh);
        foreach (b[i]) begin
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk); rx_valid = 0; rx_sop = 0; rx_eop = 0;
            end
            @(negedge clk);
            rx_valid = 1; rx_byte = b[i];
            rx_sop = (i == 0); rx_eop = (i == b.size() - 1);
            rx_is_fh = (i == 0) ? fh : 1'($urandom);
        end
        @(negedge clk);
        rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_is_fh = 0;
        @(negedge clk);
        check(accept_count == CNT_W'(exp_acc), "R9", "accept_count", 32'(accept_count), 32'(exp_acc));
        check(drop_count == CNT_W'(exp_drop), "R8", "drop_count", 32'(drop_count), 32'(exp_drop));
    endtask

    task automatic drain(input string req);
        while (ent_valid) begin
            if (exp_q.size() == 0) begin
                check(0, req, "unexpected entry", ent_data, 32'h0);
            end else begin
                logic [31:0] e = exp_q.pop_front();
                check(ent_data == e, req, "entry", ent_data, e);
            end
            ent_ready = 1;
            @(negedge clk);
            ent_ready = 0;
        end
        check(exp_q.size() == 0, req, "missing entries", 32'(exp_q.size()), 32'h0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check(!ent_valid, "R10", "ent_valid", 32'(ent_valid), 0);
        check(accept_count == 0 && drop_count == 0, "R10", "counters",
              {accept_count, drop_count}, 0);

        // R2 R3 R4: mixed addresses, field layout preserved
        pkt_ents = '{mk(3'd1, 8'h21, 12'hABC, 9'h1F3), mk(3'd3, 8'h22, 12'h001, 9'h005),
                     mk(3'd2, 8'hFF, 12'h000, 9'h100), mk(3'd0, 8'h21, 12'hFFF, 9'h000)};
        send_pkt(1, 0);
        drain("R2");

        // R1: non-frame-header packet with matching entries has no effect
        pkt_ents = '{mk(3'd3, 8'h21, 12'h123, 9'h011), mk(3'd4, 8'hFF, 12'h7, 9'h2)};
        send_pkt(0, 0);
        check(!ent_valid, "R1", "ent_valid after non-FH", 32'(ent_valid), 0);
        drain("R1");

        // R5: end-of-map stops parsing, later matches ignored
        pkt_ents = '{mk(3'd4, 8'h21, 12'h55, 9'h3), mk(3'd7, 8'h21, 12'h0, 9'h0),
                     mk(3'd1, 8'h21, 12'h66, 9'h4)};
        send_pkt(1, 0);
        drain("R5");

        // R8: more matches than depth
        pkt_ents = '{};
        for (int i = 0; i < 7; i++) pkt_ents.push_back(mk(3'd3, 8'h21, 12'(i), 9'(i)));
        send_pkt(1, 0);
        drain("R8");

        // R6: trailing partial entry dropped, last full entry on eop kept
        pkt_ents = '{mk(3'd3, 8'h21, 12'h9, 9'h9)};
        send_pkt(1, 3);
        drain("R6");

        // R4: broadcast while own address differs; R7 order across two packets
        my_mt_addr = 8'h40;
        pkt_ents = '{mk(3'd2, 8'hFF, 12'h1, 9'h1), mk(3'd3, 8'h21, 12'h2, 9'h2)};
        send_pkt(1, 0);
        pkt_ents = '{mk(3'd3, 8'h40, 12'h3, 9'h3)};
        send_pkt(1, 0);
        drain("R7");

        // random packets
        gaps = 1;
        for (int n = 0; n < 60; n++) begin
            int cnt = $urandom % 9;
            if ($urandom % 5 == 0) my_mt_addr = 8'($urandom % 4 + 8'h20);
            pkt_ents = '{};
            for (int i = 0; i < cnt; i++) begin
                logic [7:0] a;
                logic [2:0] k;
                case ($urandom % 3)
                    0: a = my_mt_addr;
                    1: a = 8'hFF;
                    default: a = 8'($urandom);
                endcase
                k = ($urandom % 12 == 0) ? 3'd7 : 3'($urandom % 7);
                pkt_ents.push_back(mk(k, a, 12'($urandom), 9'($urandom)));
            end
            send_pkt(1'($urandom % 4 != 0), $urandom % 4);
            if ($urandom % 3 != 0) drain("R3");
        end
        drain("R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule